// File: doc/BRIEF.md
# Fixed-Point to Mini-Float Normalizer

This block takes an unsigned fixed-point number with a parameterised count of integer and fraction bits and turns it into a compact 16-bit floating word. The word holds a 10-bit fractional mantissa whose first bit is an explicit leading one, followed by a 6-bit two's-complement exponent. The value it stands for is 0.m × 2^e. The position of the binary point is found by a search that shifts the operand left by one place per clock, and each shift lowers the exponent by one, until the top bit is set. Any bits below the mantissa window are dropped, and a flag reports whether a dropped bit was 1.

Operands enter on a valid/ready stream and results leave on another. The input side accepts a word only while the block is idle, so `in_ready` is the back-pressure toward the producer. After a transfer it stays low until the result has been taken. The output side holds `out_valid`, `out_word` and `out_inexact` steady for as long as the consumer keeps `out_ready` low. A result transfers on any clock edge where `out_valid` and `out_ready` are both high, and the block becomes ready again on the next cycle.

Top module: `fx2mf_norm`

## Requirements
- R1: The result word carries the mantissa in bits [15:6] and the exponent, in two's complement, in bits [5:0], so that it represents 0.mantissa × 2^exponent. Example: 5.75 (input 0x05C0) gives mantissa 1011100000 and exponent +3.
- R2: For a nonzero input whose highest set bit is at position p (bit 0 is the LSB), the result has mantissa bit 15 set and exponent p + 1 − FRAC_W. Example: input 0x0001 gives exponent −7.
- R3: The mantissa holds the 10 input bits that start at position p and run downward. Bits below that window are discarded, and the window is padded with zeros when fewer than 10 bits lie below p.
- R4: `out_inexact` is 1 exactly when at least one discarded bit was 1. It is 0 for a zero input.
- R5: A zero input produces an all-zero word with `out_inexact` low. `out_valid` is high in the cycle right after the accepting edge.
- R6: For a nonzero input, `out_valid` rises INT_W + FRAC_W − p clock edges after the accepting edge.
- R7: `in_ready` is high only while no operand is in flight. `in_valid` and `in_data` have no effect from the accepting edge until the result has been taken.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word` and `out_inexact` stay unchanged. After the output transfer, `in_ready` is high and `out_valid` is low on the next cycle.
- R9: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block idle and able to take an operand |
| in_data | input | INT_W+FRAC_W | Unsigned fixed-point operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | MANT_W+EXP_W | Mantissa in the upper field, exponent in the lower field |
| out_inexact | output | 1 | A discarded bit was 1 |

## Verification
The hardest cases to reach are the two ends of the exponent range, together with truncation. These are a lone low bit that needs the longest shift run, and a full-width operand where every bit below the window can be lost. The stimulus places the leading one at every position in turn and fills the bits under it from a shift-register sequence, so that each position is seen both with and without discarded ones. While the search is running, runs also alternate between junk operands offered on the input and held-back output transfers.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_DONE = 2'd2
  } nrm_state_t;
endpackage

// File: rtl/nrm_ctrl.sv
module nrm_ctrl
  import nrm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic din_zero,
  input  logic top_bit,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic step
);
  nrm_state_t state, state_nx;

  always_comb begin
    state_nx  = state;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    load      = 1'b0;
    step      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        in_ready = 1'b1;
        if (in_valid) begin
          load     = 1'b1;
          state_nx = din_zero ? ST_DONE : ST_SEEK;
        end
      end
      ST_SEEK: begin
        if (top_bit) state_nx = ST_DONE;
        else         step     = 1'b1;
      end
      ST_DONE: begin
        out_valid = 1'b1;
        if (out_ready) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // Searching never runs past a set top bit.
  assert_seek_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEEK && top_bit) |=> (state == ST_DONE));

  // Once a result is offered, it stays offered until taken.
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !out_ready) |=> (state == ST_DONE));
endmodule

// File: rtl/nrm_seek.sv
module nrm_seek #(
  parameter int W     = 16,
  parameter int INT_W = 8,
  parameter int EXP_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic [W-1:0]            din,
  output logic [W-1:0]            sh,
  output logic signed [EXP_W-1:0] ex
);
  localparam logic signed [EXP_W-1:0] EXP_TOP = EXP_W'(INT_W);
  localparam logic signed [EXP_W-1:0] EXP_ONE = EXP_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      ex <= '0;
    end else if (load) begin
      sh <= din;
      ex <= (din == '0) ? '0 : EXP_TOP;
    end else if (step) begin
      sh <= {sh[W-2:0], 1'b0};
      ex <= ex - EXP_ONE;
    end
  end

  // Each shift lowers the exponent by exactly one.
  assert_exp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ex == $past(ex) - EXP_ONE));

  // A shift only ever happens while the top bit is clear.
  assert_shift_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> !sh[W-1]);
endmodule

// File: rtl/nrm_pack.sv
module nrm_pack #(
  parameter int W      = 16,
  parameter int MANT_W = 10,
  parameter int EXP_W  = 6
) (
  input  logic [W-1:0]              sh,
  input  logic signed [EXP_W-1:0]   ex,
  output logic [MANT_W+EXP_W-1:0]   word,
  output logic                      inexact
);
  logic [MANT_W-1:0] mant;

  generate
    if (W > MANT_W) begin : g_trunc
      assign mant    = sh[W-1 -: MANT_W];
      assign inexact = |sh[W-MANT_W-1:0];
    end else if (W == MANT_W) begin : g_exact
      assign mant    = sh;
      assign inexact = 1'b0;
    end else begin : g_pad
      assign mant    = {sh, {(MANT_W-W){1'b0}}};
      assign inexact = 1'b0;
    end
  endgenerate

  assign word = {mant, ex};
endmodule

// File: rtl/fx2mf_norm.sv
module fx2mf_norm #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 8,
  parameter int MANT_W = 10,
  parameter int EXP_W  = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [INT_W+FRAC_W-1:0]      in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [MANT_W+EXP_W-1:0]      out_word,
  output logic                         out_inexact
);
  localparam int W     = INT_W + FRAC_W;
  localparam int OUT_W = MANT_W + EXP_W;

  logic                    load, step;
  logic [W-1:0]            sh;
  logic signed [EXP_W-1:0] ex;

  nrm_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .din_zero  (in_data == '0),
    .top_bit   (sh[W-1]),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .step      (step)
  );

  nrm_seek #(.W(W), .INT_W(INT_W), .EXP_W(EXP_W)) u_seek (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .din   (in_data),
    .sh    (sh),
    .ex    (ex)
  );

  nrm_pack #(.W(W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_pack (
    .sh      (sh),
    .ex      (ex),
    .word    (out_word),
    .inexact (out_inexact)
  );

  assert_norm_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word != '0) |-> out_word[OUT_W-1]);

  assert_zero_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data == '0) |=> (out_valid && out_word == '0));

  assert_zero_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word == '0) |-> !out_inexact);

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_word) && $stable(out_inexact)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

// File: tb/sim_fx2mf_norm.sv
module sim_fx2mf_norm;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 8;
  localparam int FW = 8;
  localparam int W  = IW + FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [15:0]   out_word;
  logic          out_inexact;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fx2mf_norm #(.INT_W(IW), .FRAC_W(FW), .MANT_W(10), .EXP_W(6)) u0 (
    .clk, .rst_n, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_word, .out_inexact
  );

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  function automatic void model(input logic [W-1:0] x, output logic [15:0] w,
                                output logic inx, output int lat);
    int p, e;
    int mant;
    p = -1;
    for (int i = 0; i < W; i++) if (x[i]) p = i;
    if (p < 0) begin
      w = 16'h0; inx = 1'b0; lat = 0;
      return;
    end
    e = p + 1 - FW;
    if (p >= 9) begin
      mant = (int'(x) >> (p - 9)) & 'h3FF;
      inx  = (int'(x) & ((1 << (p - 9)) - 1)) != 0;
    end else begin
      mant = (int'(x) << (9 - p)) & 'h3FF;
      inx  = 1'b0;
    end
    w   = {mant[9:0], e[5:0]};
    lat = W - p;
  endfunction

  // One operand through the block; hold = cycles of back-pressure, junk = offer garbage while busy.
  task automatic run(input logic [W-1:0] x, input int hold, input bit junk);
    logic [15:0] ew, w0;
    logic ei, i0;
    int el, cyc;
    model(x, ew, ei, el);
    @(negedge clk);
    in_valid = 1'b1; in_data = x;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin in_valid = 1'b1; in_data = ~x; end
    else      in_valid = 1'b0;
    cyc = 0;
    while (!out_valid && cyc < 64) begin
      if (in_ready) chk("R7", 1, 0, "in_ready while busy");
      @(negedge clk); cyc++;
    end
    in_valid = 1'b0;
    chk(x == 0 ? "R5" : "R6", cyc, el, "latency");
    chk("R2", out_word, ew, "word");
    chk("R4", out_inexact, ei, "inexact");
    w0 = out_word; i0 = out_inexact;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R8", {out_valid, out_inexact, out_word}, {1'b1, i0, w0}, "held result");
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8", {in_ready, out_valid}, 2'b10, "release");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", {in_ready, out_valid}, 2'b10, "reset state");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", {in_ready, out_valid}, 2'b10, "after reset");

    // R1: 5.75 -> mantissa 1011100000, exponent +3
    run(16'h05C0, 0, 0);
    chk("R1", out_word, 16'b1011100000_000011, "5.75 word (last)");
    // R2: smallest value -> exponent -7
    run(16'h0001, 2, 1);
    chk("R2", out_word, 16'b1000000000_111001, "lsb word (last)");
    // R4: full operand loses ones
    run(16'hFFFF, 1, 0);
    chk("R4", out_inexact, 1, "ffff inexact");
    // R3: 2.98 approx -> 10.11111010
    run(16'h02FA, 0, 1);
    chk("R3", out_word, 16'b1011111010_000010, "2.98 word");
    // R5: zero with junk offered
    run(16'h0000, 3, 1);
    chk("R5", {out_word, out_inexact}, 17'h0, "zero word");

    // Sweep of every leading-one position with pseudo-random lower bits
    for (int p = 0; p < W; p++) begin
      for (int k = 0; k < 40; k++) begin
        logic [W-1:0] x;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        x = (W'(1) << p) | (lfsr & ((W'(1) << p) - W'(1)));
        if (k == 0) x = W'(1) << p;
        run(x, k % 3, k[0]);
      end
    end
    summary();
  end
endmodule